// File: doc/BRIEF.md
# Hierarchical Pseudo-LRU Victim Selector

This block picks which way of a 4-way set-associative cache to replace on a miss. It keeps three bits of recency state per set instead of a full ordering: the four ways form two pairs (ways 0 and 1 are pair 0, ways 2 and 3 are pair 1). For each set it stores which pair was touched last, and for each pair which of its two ways was touched last.

On every cycle the cache controller presents a set index and that set's valid vector. The block answers at once, without a clock edge, with the way to replace. An empty way always wins. Only a full set falls back to the recency bits, which point at the older way of the older pair. In the same cycle the controller may report a hit, a fill or both. The block then records the touched way as most recent in the addressed set, and the change shows in the victim output from the next cycle on.

Top module: `plru_victim_sel`

## Requirements
- R1: If at least one bit of `way_valid` is 0, `victim_way` names a way whose valid bit is 0, whatever the recency state.
- R2: If several ways are invalid, `victim_way` is the lowest-numbered one (bit i of `way_valid` belongs to way i).
- R3: If all four ways are valid, `victim_way` is the less recent way inside the less recent pair. Pair 0 holds ways 0 and 1, and pair 1 holds ways 2 and 3.
- R4: A cycle with `hit_en` high and `fill_en` low makes `hit_way` the most recent way of its pair, and its pair the most recent pair, in set `lookup_set`. This shows from the next cycle on.
- R5: A cycle with `fill_en` high makes `fill_way` most recent in the same way as R4.
- R6: If `hit_en` and `fill_en` are both high in one cycle, only `fill_way` is recorded and `hit_way` is ignored.
- R7: A synchronous reset (`rst` high at a rising edge) clears every set to the state "pair 0 most recent, way 0 and way 2 most recent in their pairs". A fully valid set then yields way 3.
- R8: An update changes only the addressed set. All other sets keep their victim choice.
- R9: A cycle with both `hit_en` and `fill_en` low leaves all recency state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lookup_set | input | SET_W | Set addressed this cycle |
| way_valid | input | 4 | Valid bit of each way of that set |
| hit_en | input | 1 | A lookup hit in this set |
| hit_way | input | 2 | Way that hit |
| fill_en | input | 1 | A line is being filled into this set |
| fill_way | input | 2 | Way being filled |
| victim_way | output | 2 | Way to replace, combinational |

## Verification
A corrupted recency bit never shows while a set still has an empty way. It appears only on the first lookup of a full set after the damage, as a wrong `victim_way` in that same cycle. A lost or misrouted update shows one cycle after the hit or fill. It can also show as a different set changing its answer. A thrashing stream of five blocks cycled through one set exercises every state bit repeatedly and exposes a wrong bit within a few accesses.

// File: rtl/plru_pkg.sv
package plru_pkg;

  localparam int WAYS  = 4;
  localparam int WAY_W = $clog2(WAYS);

  // grp    : pair touched last (0 = ways 0/1, 1 = ways 2/3)
  // mru_g1 : way touched last inside pair 1 (0 = way 2, 1 = way 3)
  // mru_g0 : way touched last inside pair 0 (0 = way 0, 1 = way 1)
  typedef struct packed {
    logic grp;
    logic mru_g1;
    logic mru_g0;
  } plru_state_t;

  // Lowest empty way; bit WAY_W of the result says whether one exists.
  function automatic logic [WAY_W:0] first_free(input logic [WAYS-1:0] valid);
    logic [WAY_W:0] res;
    res = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!valid[i]) res = {1'b1, WAY_W'(i)};
    end
    return res;
  endfunction

  // Older way of the older pair.
  function automatic logic [WAY_W-1:0] tree_victim(input plru_state_t st);
    logic old_pair;
    logic old_way;
    old_pair = ~st.grp;
    old_way  = old_pair ? ~st.mru_g1 : ~st.mru_g0;
    return {old_pair, old_way};
  endfunction

  // Mark one way as most recent.
  function automatic plru_state_t touch(input plru_state_t st,
                                        input logic [WAY_W-1:0] way);
    plru_state_t nx;
    nx     = st;
    nx.grp = way[1];
    if (way[1]) nx.mru_g1 = way[0];
    else        nx.mru_g0 = way[0];
    return nx;
  endfunction

endpackage

// File: rtl/plru_state_array.sv
module plru_state_array
  import plru_pkg::*;
#(
  parameter int NUM_SETS = 8,
  localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [SET_W-1:0]           wr_set,
  input  plru_state_t                wr_state,
  input  logic [SET_W-1:0]           rd_set,
  output plru_state_t                rd_state,
  output plru_state_t [NUM_SETS-1:0] all_state
);

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    logic sel;
    assign sel = wr_en && (wr_set == SET_W'(s));
    always_ff @(posedge clk) begin
      if (rst)      all_state[s] <= '0;
      else if (sel) all_state[s] <= wr_state;
    end
  end

  assign rd_state = all_state[rd_set];

  // R7: every set is cleared by reset
  p_reset_clear_r7: assert property (@(posedge clk) rst |=> (all_state == '0));

  // R9: nothing moves without a write
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(all_state));

endmodule

// File: rtl/plru_update.sv
module plru_update
  import plru_pkg::*;
(
  input  logic             hit_en,
  input  logic [WAY_W-1:0] hit_way,
  input  logic             fill_en,
  input  logic [WAY_W-1:0] fill_way,
  input  plru_state_t      cur_state,
  output logic             upd_en,
  output logic [WAY_W-1:0] upd_way,
  output plru_state_t      nxt_state
);

  // A fill takes priority over a hit in the same cycle.
  always_comb begin
    upd_en  = hit_en | fill_en;
    upd_way = fill_en ? fill_way : hit_way;
  end

  assign nxt_state = touch(cur_state, upd_way);

endmodule

// File: rtl/plru_victim_pick.sv
module plru_victim_pick
  import plru_pkg::*;
(
  input  logic [WAYS-1:0]  way_valid,
  input  plru_state_t      cur_state,
  output logic             use_free,
  output logic [WAY_W-1:0] victim_way
);

  logic [WAY_W:0]   free_res;
  logic [WAY_W-1:0] tree_way;

  assign free_res   = first_free(way_valid);
  assign tree_way   = tree_victim(cur_state);
  assign use_free   = free_res[WAY_W];
  assign victim_way = use_free ? free_res[WAY_W-1:0] : tree_way;

endmodule

// File: rtl/plru_victim_sel.sv
module plru_victim_sel
  import plru_pkg::*;
#(
  parameter int NUM_SETS = 8,
  localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] lookup_set,
  input  logic [3:0]       way_valid,
  input  logic             hit_en,
  input  logic [1:0]       hit_way,
  input  logic             fill_en,
  input  logic [1:0]       fill_way,
  output logic [1:0]       victim_way
);

  plru_state_t                cur_state;
  plru_state_t                nxt_state;
  plru_state_t [NUM_SETS-1:0] all_state;
  logic                       upd_en;
  logic [WAY_W-1:0]           upd_way;
  logic                       use_free;

  plru_state_array #(.NUM_SETS(NUM_SETS)) u_state (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (upd_en),
    .wr_set    (lookup_set),
    .wr_state  (nxt_state),
    .rd_set    (lookup_set),
    .rd_state  (cur_state),
    .all_state (all_state)
  );

  plru_update u_update (
    .hit_en    (hit_en),
    .hit_way   (hit_way),
    .fill_en   (fill_en),
    .fill_way  (fill_way),
    .cur_state (cur_state),
    .upd_en    (upd_en),
    .upd_way   (upd_way),
    .nxt_state (nxt_state)
  );

  plru_victim_pick u_pick (
    .way_valid  (way_valid),
    .cur_state  (cur_state),
    .use_free   (use_free),
    .victim_way (victim_way)
  );

  // R1: an empty way is never passed over
  p_empty_first_r1: assert property (@(posedge clk) disable iff (rst)
    (way_valid != 4'hF) |-> (use_free && !way_valid[victim_way]));

  // R2: every way below the choice is occupied
  p_lowest_empty_r2: assert property (@(posedge clk) disable iff (rst)
    (way_valid != 4'hF) |->
      ((way_valid & ((4'b0001 << victim_way) - 4'b0001)) ==
       ((4'b0001 << victim_way) - 4'b0001)));

  // R4: a lone hit becomes most recent in its set
  p_hit_promote_r4: assert property (@(posedge clk) disable iff (rst)
    (hit_en && !fill_en) |=>
      (all_state[$past(lookup_set)].grp == $past(hit_way[1])) &&
      (($past(hit_way[1]) ? all_state[$past(lookup_set)].mru_g1
                          : all_state[$past(lookup_set)].mru_g0) == $past(hit_way[0])));

  // R5: a fill becomes most recent in its set
  p_fill_insert_r5: assert property (@(posedge clk) disable iff (rst)
    fill_en |=>
      (all_state[$past(lookup_set)].grp == $past(fill_way[1])) &&
      (($past(fill_way[1]) ? all_state[$past(lookup_set)].mru_g1
                           : all_state[$past(lookup_set)].mru_g0) == $past(fill_way[0])));

  // R6: with both strobes, the pair of the hit way is not recorded
  p_fill_wins_r6: assert property (@(posedge clk) disable iff (rst)
    (hit_en && fill_en && (hit_way[1] != fill_way[1])) |=>
      (all_state[$past(lookup_set)].grp != $past(hit_way[1])));

endmodule

// File: tb/plru_victim_sel_tb.sv
module plru_victim_sel_tb;

  localparam int NUM_SETS = 8;
  localparam int SET_W    = 3;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [SET_W-1:0] lookup_set = '0;
  logic [3:0]       way_valid  = 4'hF;
  logic             hit_en     = 1'b0;
  logic [1:0]       hit_way    = '0;
  logic             fill_en    = 1'b0;
  logic [1:0]       fill_way   = '0;
  logic [1:0]       victim_way;

  always #10 clk = ~clk;

  plru_victim_sel #(.NUM_SETS(NUM_SETS)) u_dut (
    .clk(clk), .rst(rst), .lookup_set(lookup_set), .way_valid(way_valid),
    .hit_en(hit_en), .hit_way(hit_way), .fill_en(fill_en), .fill_way(fill_way),
    .victim_way(victim_way)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Model: pair touched last, and per pair the offset (0/1) touched last.
  int m_pair [NUM_SETS];
  int m_off  [NUM_SETS][2];

  int    q_exp[$];
  string q_req[$];

  function automatic int model_victim(int s, logic [3:0] v);
    for (int w = 0; w < 4; w++) if (v[w] == 1'b0) return w;
    return (1 - m_pair[s]) * 2 + (1 - m_off[s][1 - m_pair[s]]);
  endfunction

  function automatic void model_touch(int s, int w);
    m_pair[s]       = w / 2;
    m_off[s][w / 2] = w % 2;
  endfunction

  task automatic drive(input int s, input logic [3:0] v, input bit h, input int hw,
                       input bit f, input int fw, input string req);
    @(negedge clk);
    lookup_set = SET_W'(s);
    way_valid  = v;
    hit_en     = h;
    hit_way    = 2'(hw);
    fill_en    = f;
    fill_way   = 2'(fw);
    q_exp.push_back(model_victim(s, v));
    q_req.push_back(req);
    if (f)      model_touch(s, fw);
    else if (h) model_touch(s, hw);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hit_en  = 1'b0;
      fill_en = 1'b0;
    end
  endtask

  // Monitor: compares mid-cycle, well before the next rising edge.
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (q_exp.size() > 0) begin
        int    e;
        string r;
        e = q_exp.pop_front();
        r = q_req.pop_front();
        checks++;
        if (int'(victim_way) != e) begin
          fails++;
          $display("FAIL %s victim=%0d expected=%0d", r, victim_way, e);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int tags[4];
    int blk;
    int hw;
    int vw;
    logic [3:0] vv;
    for (int s = 0; s < NUM_SETS; s++) begin
      m_pair[s] = 0; m_off[s][0] = 0; m_off[s][1] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R7: cleared state, full set gives way 3
    drive(0, 4'hF, 0, 0, 0, 0, "R7 reset set0");
    drive(NUM_SETS - 1, 4'hF, 0, 0, 0, 0, "R7 reset last set");

    // R1: a single empty way wins over state
    drive(0, 4'b1011, 0, 0, 0, 0, "R1 way2 empty");
    drive(0, 4'b0111, 0, 0, 0, 0, "R1 way3 empty");
    // R2: lowest empty way
    drive(0, 4'b0000, 0, 0, 0, 0, "R2 all empty");
    drive(0, 4'b1010, 0, 0, 0, 0, "R2 ways0,2 empty");
    drive(0, 4'b0101, 0, 0, 0, 0, "R2 ways1,3 empty");
    drive(0, 4'b1001, 0, 0, 0, 0, "R2 ways1,2 empty");

    // R4: hits promote
    drive(0, 4'hF, 1, 1, 0, 0, "R4 hit way1");
    drive(0, 4'hF, 1, 3, 0, 0, "R4 after hit way1");
    drive(0, 4'hF, 0, 0, 0, 0, "R4 after hit way3");
    drive(0, 4'hF, 1, 2, 0, 0, "R4 hit way2");
    drive(0, 4'hF, 0, 0, 0, 0, "R4 after hit way2");
    // R1 again with non-reset state
    drive(0, 4'b1110, 0, 0, 0, 0, "R1 way0 empty, state set");

    // R5: fills insert as most recent
    drive(0, 4'hF, 0, 0, 1, 1, "R5 fill way1");
    drive(0, 4'hF, 0, 0, 0, 0, "R5 after fill way1");
    drive(0, 4'hF, 0, 0, 1, 3, "R5 fill way3");
    drive(0, 4'hF, 0, 0, 0, 0, "R5 after fill way3");

    // R6: fill way 0 beats hit way 3 in one cycle
    drive(1, 4'hF, 1, 3, 1, 0, "R6 hit3+fill0");
    drive(1, 4'hF, 0, 0, 0, 0, "R6 after hit3+fill0");
    drive(1, 4'hF, 1, 0, 1, 2, "R6 hit0+fill2");
    drive(1, 4'hF, 0, 0, 0, 0, "R6 after hit0+fill2");

    // R9: idle cycles leave state alone
    idle(4);
    drive(0, 4'hF, 0, 0, 0, 0, "R9 set0 after idle");
    drive(1, 4'hF, 0, 0, 0, 0, "R9 set1 after idle");

    // R8: updates to set 4 leave sets 0, 1, 5 untouched
    drive(4, 4'hF, 1, 0, 0, 0, "R8 hit set4");
    drive(4, 4'hF, 0, 0, 1, 2, "R8 fill set4");
    drive(0, 4'hF, 0, 0, 0, 0, "R8 set0 unchanged");
    drive(1, 4'hF, 0, 0, 0, 0, "R8 set1 unchanged");
    drive(5, 4'hF, 0, 0, 0, 0, "R8 set5 unchanged");
    drive(4, 4'hF, 0, 0, 0, 0, "R8 set4 updated");

    // R3/R5: five blocks cycled through empty set 2
    for (int w = 0; w < 4; w++) tags[w] = -1;
    for (int n = 0; n < 25; n++) begin
      blk = n % 5;
      hw  = -1;
      vv  = '0;
      for (int w = 0; w < 4; w++) begin
        vv[w] = (tags[w] >= 0);
        if (tags[w] == blk) hw = w;
      end
      if (hw >= 0) begin
        drive(2, vv, 1, hw, 0, 0, "R3 cyclic hit");
      end else begin
        vw = model_victim(2, vv);
        drive(2, vv, 0, 0, 1, vw, "R3 R5 cyclic miss");
        tags[vw] = blk;
      end
    end
    drive(2, 4'hF, 0, 0, 0, 0, "R3 cyclic final");

    idle(2);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule